// File: doc/BRIEF.md
# Per-Channel CAS Signaling Source Selector

This block builds the timeslot-16 byte of an E1 transmitter that carries channel-associated signaling. Each byte holds two 4-bit signaling nibbles: in frame f of the 16-frame multiframe (f = 0..15), the upper nibble belongs to voice channel f+1 and the lower nibble to channel f+17. For every nibble the block picks one of two sources. One source is a byte shifted in bit by bit from a backplane signaling input. The other is a bank of sixteen internal 8-bit signaling registers, where register f serves frame f.

A 32-bit per-channel select mask, written as four 8-bit registers, decides the source for each channel. It does so only while the source-select mode bit and both insertion enables are set. The mask registers interleave channel n with channel n+16. The mask that is applied is copied from the written registers only at the start of a multiframe, so one multiframe never mixes two settings.

Frame 0 carries the multiframe alignment word and the spare and remote-alarm bits. These come from internal register 0, which is why channels 1 and 17 are normally selected as internal. The timeslot and frame counters come from an external framer. The block only reads them, on a per-slot strobe.

Top module: `cas_sig_src_sel`

## Requirements
- R1: After a synchronous active-low reset, `ts16_byte` is 0x00, `ts16_vld` is 0, every register is 0, and the applied select mask is all zeros, so every nibble comes from the backplane.
- R2: `ts16_vld` is 1 in exactly the cycle after a cycle with `slot_stb`=1 and `ts_idx`=16, and 0 otherwise. `ts16_byte` changes only at that edge.
- R3: While control bit 0 (source-select mode) is 0, the whole output byte equals the captured backplane byte, whatever the mask holds.
- R4: Write address 0x10+r (r = 0..3) holds mask register r. Its bit b selects 0-based channel index 4r + b/2 + 16·(b mod 2). Register 0 therefore holds, from MSB to LSB, channels 20, 4, 19, 3, 18, 2, 17, 1.
- R5: In frame f, the upper nibble is taken from internal register f bits [7:4] when channel f+1's applied select bit is 1, and from backplane bits [7:4] otherwise. The lower nibble is taken in the same way from bits [3:0], using the select bit of channel f+17.
- R6: The internal source is used only when control bits 1 (timeslot-16 insertion enable) and 2 (hardware-signaling enable) are both 1, in addition to the mode bit. Otherwise the backplane byte is sent.
- R7: Writes to the mask registers take effect only at a strobe with `ts_idx`=0 and `frm_idx`=0. Frames sent before that strobe keep the previous mask.
- R8: With internal register 0 (address 0x00) holding 0x0B and channels 1 and 17 selected, the frame-0 byte is 0x0B: alignment nibble 0000, then the spare and alarm bits 1011.
- R9: The backplane byte is made of the last eight bits accepted on `bp_sig_vld` before the timeslot-16 strobe, first bit in the MSB. Earlier bits are discarded.
- R10: Addresses 0x00..0x0F write the internal signaling registers and take effect immediately. Address 0x14 writes the control bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| slot_stb | input | 1 | Marks a cycle that carries a valid timeslot position |
| ts_idx | input | 5 | Timeslot number within the frame, 0..31 |
| frm_idx | input | 4 | Frame number within the multiframe, 0..15 |
| bp_sig_vld | input | 1 | Backplane signaling bit valid |
| bp_sig_bit | input | 1 | Backplane signaling serial bit |
| ts16_byte | output | 8 | Timeslot-16 signaling byte for the current frame |
| ts16_vld | output | 1 | One-cycle pulse when `ts16_byte` is updated |

## Verification
The output byte and its valid pulse are registered once, so both are due in the cycle after the timeslot-16 strobe. The bench drives inputs on the falling edge and checks the byte and the pulse at the falling edge that follows the timeslot-16 strobe, then checks again one slot later that the pulse has cleared. A mask change counts from the next frame-0 timeslot-0 strobe. The bench writes new masks halfway through a multiframe and copies the written values into its applied-mask model only when it issues that strobe. Internal-register and control writes apply at the next edge, and the bench's model takes them at once.

// File: rtl/cas_sel_pkg.sv
// Package: shared constants and types for the CAS signaling source selector.
// Assumes a 32-slot E1 frame and a 16-frame signaling multiframe.
package cas_sel_pkg;
    localparam int DATA_W   = 8;
    localparam int TS_W     = 5;
    localparam int FRM_W    = 4;
    localparam int NUM_SIG  = 1 << FRM_W;          // internal signaling registers
    localparam int NUM_CH   = 2 * NUM_SIG;         // voice channels carrying CAS
    localparam int NUM_MASK = NUM_CH / DATA_W;     // select mask registers
    localparam int ADDR_W   = 5;
    localparam int NIB_W    = DATA_W / 2;

    localparam logic [ADDR_W-1:0] ADDR_MASK0 = 5'h10;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'h14;

    // Control bits: [0] source-select mode, [1] ts16 insertion, [2] hardware signaling.
    typedef struct packed {
        logic hw_en;
        logic ins_en;
        logic mode;
    } ctrl_t;
endpackage

// File: rtl/cas_reg_bank.sv
// Module: write-only register bank holding the internal signaling bytes,
// the four raw select-mask registers and the control bits.
// Assumes single-cycle writes; there is no read path.
module cas_reg_bank
    import cas_sel_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_SIG-1:0][DATA_W-1:0]     sig_regs,
    output logic [NUM_MASK-1:0][DATA_W-1:0]    mask_regs,
    output ctrl_t                              ctrl
);
    // Internal signaling registers, one per frame of the multiframe.
    for (genvar i = 0; i < NUM_SIG; i++) begin : g_sig
        always_ff @(posedge clk) begin
            if (!rst_n)
                sig_regs[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))
                sig_regs[i] <= wr_data;
        end
    end

    // Raw select-mask registers as written; applied later at a multiframe start.
    for (genvar r = 0; r < NUM_MASK; r++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_regs[r] <= '0;
            else if (wr_en && wr_addr == ADDR_MASK0 + ADDR_W'(r))
                mask_regs[r] <= wr_data;
        end
    end

    // Control bits, effective immediately.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)
            ctrl <= ctrl_t'(wr_data[2:0]);
    end
endmodule

// File: rtl/cas_mask_unpack.sv
// Module: reorders the interleaved mask registers into a per-channel select
// vector and holds the applied copy, reloaded only on a multiframe start.
// Assumes mask register r bit b maps to channel index 4r + b/2 + 16*(b%2).
module cas_mask_unpack
    import cas_sel_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [NUM_MASK-1:0][DATA_W-1:0]    mask_regs,
    output logic [NUM_CH-1:0]                  act_sel
);
    localparam int PAIRS = DATA_W / 2;

    logic [NUM_CH-1:0] chan_sel;

    // Scatter each register bit to its channel position.
    for (genvar r = 0; r < NUM_MASK; r++) begin : g_reg
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam int CH = r * PAIRS + b / 2 + (b % 2) * NUM_SIG;
            assign chan_sel[CH] = mask_regs[r][b];
        end
    end

    // Applied mask, refreshed only at the multiframe boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_sel <= '0;
        else if (load)
            act_sel <= chan_sel;
    end
endmodule

// File: rtl/cas_ser_capture.sv
// Module: shifts in backplane signaling bits, first bit toward the MSB,
// keeping the most recent byte.
// Assumes the framer supplies eight bits before each timeslot-16 strobe.
module cas_ser_capture
    import cas_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [DATA_W-1:0] bp_byte
);
    // Shift register: oldest retained bit ends in the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bp_byte <= '0;
        else if (bit_vld)
            bp_byte <= {bp_byte[DATA_W-2:0], bit_in};
    end
endmodule

// File: rtl/cas_ts16_mux.sv
// Module: forms the timeslot-16 byte from backplane and internal nibbles
// using the applied per-channel select and control bits.
// Assumes fire is a single-cycle strobe at timeslot 16.
module cas_ts16_mux
    import cas_sel_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fire,
    input  logic [FRM_W-1:0]                   frm_idx,
    input  ctrl_t                              ctrl,
    input  logic [NUM_CH-1:0]                  act_sel,
    input  logic [NUM_SIG-1:0][DATA_W-1:0]     sig_regs,
    input  logic [DATA_W-1:0]                  bp_byte,
    output logic [DATA_W-1:0]                  ts16_byte,
    output logic                               ts16_vld
);
    logic              use_int;
    logic              sel_hi;
    logic              sel_lo;
    logic [DATA_W-1:0] int_byte;
    logic [NIB_W-1:0]  nib_hi;
    logic [NIB_W-1:0]  nib_lo;

    // Per-nibble source choice for the current frame.
    always_comb begin
        use_int  = ctrl.mode & ctrl.ins_en & ctrl.hw_en;
        sel_hi   = use_int & act_sel[{1'b0, frm_idx}];
        sel_lo   = use_int & act_sel[{1'b1, frm_idx}];
        int_byte = sig_regs[frm_idx];
        nib_hi   = sel_hi ? int_byte[DATA_W-1:NIB_W] : bp_byte[DATA_W-1:NIB_W];
        nib_lo   = sel_lo ? int_byte[NIB_W-1:0]      : bp_byte[NIB_W-1:0];
    end

    // Output register, updated once per frame at timeslot 16.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts16_byte <= '0;
            ts16_vld  <= 1'b0;
        end else begin
            ts16_vld <= fire;
            if (fire)
                ts16_byte <= {nib_hi, nib_lo};
        end
    end
endmodule

// File: rtl/cas_sig_src_sel.sv
// Module: top of the CAS signaling source selector. Registers, mask
// unpacking, backplane capture and the timeslot-16 multiplexer.
// Assumes ts_idx/frm_idx are valid whenever slot_stb is high.
module cas_sig_src_sel
    import cas_sel_pkg::*;
#(
    parameter int TS16_SLOT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              slot_stb,
    input  logic [4:0]        ts_idx,
    input  logic [3:0]        frm_idx,
    input  logic              bp_sig_vld,
    input  logic              bp_sig_bit,
    output logic [7:0]        ts16_byte,
    output logic              ts16_vld
);
    logic [NUM_SIG-1:0][DATA_W-1:0]  sig_regs;
    logic [NUM_MASK-1:0][DATA_W-1:0] mask_regs;
    ctrl_t                           ctrl_q;
    logic [NUM_CH-1:0]               act_sel;
    logic [DATA_W-1:0]               bp_byte;
    logic                            mf_start;
    logic                            fire;

    // Position decode: multiframe start and timeslot-16 strobe.
    always_comb begin
        mf_start = slot_stb && ts_idx == '0 && frm_idx == '0;
        fire     = slot_stb && ts_idx == TS_W'(TS16_SLOT);
    end

    cas_reg_bank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sig_regs  (sig_regs),
        .mask_regs (mask_regs),
        .ctrl      (ctrl_q)
    );

    cas_mask_unpack u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mf_start),
        .mask_regs (mask_regs),
        .act_sel   (act_sel)
    );

    cas_ser_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bp_sig_vld),
        .bit_in  (bp_sig_bit),
        .bp_byte (bp_byte)
    );

    cas_ts16_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .frm_idx   (frm_idx),
        .ctrl      (ctrl_q),
        .act_sel   (act_sel),
        .sig_regs  (sig_regs),
        .bp_byte   (bp_byte),
        .ts16_byte (ts16_byte),
        .ts16_vld  (ts16_vld)
    );
endmodule

// File: rtl/cas_sig_src_sel_chk.sv
// Module: assertion checker bound to cas_sig_src_sel.
// Assumes the bind below connects the internal capture, control and mask state.
module cas_sig_src_sel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        slot_stb,
    input logic [4:0]  ts_idx,
    input logic [3:0]  frm_idx,
    input logic [7:0]  ts16_byte,
    input logic        ts16_vld,
    input logic [7:0]  bp_byte,
    input logic [2:0]  ctrl_bits,
    input logic [31:0] act_sel
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (ts16_byte == 8'h00 && !ts16_vld && act_sel == '0)); // R1

    AST_VLD_AFTER_TS16: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && ts_idx == 5'd16) |=> ts16_vld); // R2

    AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_stb && ts_idx == 5'd16) |=> (!ts16_vld && $stable(ts16_byte))); // R2

    AST_MODE_OFF_BACKPLANE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && ts_idx == 5'd16 && !ctrl_bits[0]) |=> (ts16_byte == $past(bp_byte))); // R3

    AST_ENABLES_OFF_BACKPLANE: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && ts_idx == 5'd16 && !(ctrl_bits[1] && ctrl_bits[2])) |=> (ts16_byte == $past(bp_byte))); // R6

    AST_MASK_HELD_IN_MF: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_stb && ts_idx == 5'd0 && frm_idx == 4'd0) |=> $stable(act_sel)); // R7
endmodule

bind cas_sig_src_sel cas_sig_src_sel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_stb  (slot_stb),
    .ts_idx    (ts_idx),
    .frm_idx   (frm_idx),
    .ts16_byte (ts16_byte),
    .ts16_vld  (ts16_vld),
    .bp_byte   (bp_byte),
    .ctrl_bits (ctrl_q),
    .act_sel   (act_sel)
);

// File: tb/cas_sig_src_sel_test.sv
// Bench: directed and seeded-random multiframes, each checked against a model.
module cas_sig_src_sel_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       slot_stb;
    logic [4:0] ts_idx;
    logic [3:0] frm_idx;
    logic       bp_sig_vld;
    logic       bp_sig_bit;
    logic [7:0] ts16_byte;
    logic       ts16_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] m_sig [16];
    logic [7:0] m_mask [4];
    logic [7:0] m_act [4];
    logic [2:0] m_ctrl;
    int unsigned seed_v;

    always #5 clk = ~clk;

    cas_sig_src_sel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .slot_stb(slot_stb), .ts_idx(ts_idx), .frm_idx(frm_idx),
        .bp_sig_vld(bp_sig_vld), .bp_sig_bit(bp_sig_bit),
        .ts16_byte(ts16_byte), .ts16_vld(ts16_vld)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Applied select bit of 0-based channel c, from the register-form model.
    function automatic logic sel_of(input int c);
        int r = (c % 16) / 4;
        int b = 2 * (c % 4) + c / 16;
        return m_act[r][b];
    endfunction

    function automatic logic [7:0] exp_byte(input int f, input logic [7:0] bp);
        logic u = m_ctrl[0] & m_ctrl[1] & m_ctrl[2];
        logic [3:0] hi = (u && sel_of(f))      ? m_sig[f][7:4] : bp[7:4];
        logic [3:0] lo = (u && sel_of(f + 16)) ? m_sig[f][3:0] : bp[3:0];
        return {hi, lo};
    endfunction

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        slot_stb = 0; bp_sig_vld = 0;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (a < 5'h10) m_sig[a] = d;
        else if (a < 5'h14) m_mask[a - 5'h10] = d;
        else if (a == 5'h14) m_ctrl = d[2:0];
    endtask

    // Runs frames f0..f1; ten bits shifted per frame so only the last eight count (R9).
    task automatic run_frames(input int f0, input int f1, input string tag);
        for (int f = f0; f <= f1; f++) begin
            logic [9:0] bits = 10'($urandom);
            logic [7:0] e = 8'h00;
            for (int ts = 0; ts < 32; ts++) begin
                @(negedge clk);
                if (ts == 17) begin
                    check("R2", {7'd0, ts16_vld}, 8'h01);
                    check(tag, ts16_byte, e);
                end
                if (ts == 18) check("R2", {7'd0, ts16_vld}, 8'h00);
                slot_stb = 1; ts_idx = 5'(ts); frm_idx = 4'(f);
                bp_sig_vld = (ts >= 6 && ts <= 15);
                bp_sig_bit = (ts >= 6 && ts <= 15) ? bits[15 - ts] : 1'b0;
                if (ts == 0 && f == 0) for (int r = 0; r < 4; r++) m_act[r] = m_mask[r];
                if (ts == 16) e = exp_byte(f, bits[7:0]);
            end
        end
    endtask

    task automatic run_mf(input string tag);
        run_frames(0, 15, tag);
    endtask

    initial begin
        seed_v = $urandom(32'h5EED_CA55);
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
        slot_stb = 0; ts_idx = 0; frm_idx = 0; bp_sig_vld = 0; bp_sig_bit = 0;
        for (int i = 0; i < 16; i++) m_sig[i] = 0;
        for (int r = 0; r < 4; r++) begin m_mask[r] = 0; m_act[r] = 0; end
        m_ctrl = 0;
        repeat (3) @(negedge clk);
        check("R1", ts16_byte, 8'h00);
        check("R1", {7'd0, ts16_vld}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        check("R1", {7'd0, ts16_vld}, 8'h00);

        // R1: enables on, mask never written -> all backplane.
        for (int i = 0; i < 16; i++) wr(5'(i), 8'($urandom));
        wr(5'h14, 8'h07);
        run_mf("R1");

        // R8: alignment word from register 0 via channels 1 and 17.
        wr(5'h00, 8'h0B);
        wr(5'h10, 8'h03);
        run_frames(0, 7, "R8");
        // R7: new mask written mid multiframe must wait for the boundary.
        for (int r = 0; r < 4; r++) wr(5'h10 + 5'(r), 8'hFF);
        run_frames(8, 15, "R7");
        run_mf("R7");

        // R4: single mask bits at several positions.
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 4; r++) wr(5'h10 + 5'(r), 8'h00);
            wr(5'h10 + 5'(k), 8'h01 << (2 * k + 1));
            run_mf("R4");
        end

        // R3: mode off, mask full.
        for (int r = 0; r < 4; r++) wr(5'h10 + 5'(r), 8'hFF);
        wr(5'h14, 8'h06);
        run_mf("R3");
        // R6: one enable missing.
        wr(5'h14, 8'h05);
        run_frames(0, 7, "R6");
        wr(5'h14, 8'h03);
        run_frames(8, 15, "R6");

        // R5 / R9 / R10: seeded random mixes, masks changed mid multiframe.
        for (int m = 0; m < 6; m++) begin
            wr(5'h14, ($urandom % 4 != 0) ? 8'h07 : 8'($urandom % 8));
            for (int i = 0; i < 4; i++) wr(5'($urandom % 16), 8'($urandom));
            run_frames(0, 7, "R5");
            for (int i = 0; i < 2; i++) wr(5'h10 + 5'($urandom % 4), 8'($urandom));
            wr(5'($urandom % 16), 8'($urandom));
            run_frames(8, 15, "R10");
        end
        run_mf("R9");

        @(negedge clk);
        slot_stb = 0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule